// File: doc/BRIEF.md
# Filtered Port Pin-Interrupt Controller

This block watches the eight pins of a general-purpose port and raises one shared interrupt request when a pin changes level in the direction that software has chosen for it. Each pin level is first brought into the bus-clock domain by a short synchronizer. It then passes through a pulse-width filter, so that a short glitch is discarded before it can mark the pin as pending. Only the level of the pin is observed, so edges are seen in the same way whether the pad is driven from outside or by the port's own output.

Software reaches three registers over a simple single-cycle register bus. A per-pin enable mask lets a pending pin reach the request. A per-pin polarity mask selects a rising or a falling edge for each pin. A per-pin pending-flag register is cleared by writing 1 to a bit. The combined request is also sent out as a wake request whenever the low-power mode input is high.

Top module: `pinIrqCtrl`

## Requirements
- R1: After reset the enable register (address 0), the polarity register (address 1) and the flag register (address 2) all read 0, and irqReq and wakeReq are low.
- R2: A bus write to address 0 or 1 loads the enable or polarity mask, and bit i of each mask belongs to pin i. A read returns the stored mask. Address 3 reads 0.
- R3: Polarity bit 1 selects a rising edge and polarity bit 0 selects a falling edge. A filtered edge in the direction that was not selected leaves the flag at 0.
- R4: A pin level that holds for 3 or fewer consecutive synchronized bus clocks before it returns is rejected and sets no flag.
- R5: A selected edge whose new level holds for 4 consecutive bus clocks sets flag bit i. Counting from the first rising clock edge that samples the new pin level, the flag reads 1 after the 6th edge and still reads 0 after the 5th edge (2 synchronizer stages plus 4 filter clocks).
- R6: Flags are set whatever the enable mask holds.
- R7: irqReq is high exactly when some pin has both its flag bit and its enable bit set.
- R8: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R9: When a clear write to a flag bit lands in the same clock as a new qualified edge on that pin, the flag stays set.
- R10: wakeReq equals irqReq while lowPwrMode is high and is low while lowPwrMode is low.
- R11: A bus write never sets a flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Pin levels of the port, asynchronous to clk |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe, valid together with busSel |
| busAddr | input | 2 | Register address: 0 enable, 1 polarity, 2 flags |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| lowPwrMode | input | 1 | High while the processor is stopped or waiting |
| irqReq | output | 1 | Shared interrupt request |
| wakeReq | output | 1 | Wake request during low-power mode |

## Verification
The assertions assume that the pin inputs may change at any time. They also assume that a bus write lasts one clock with busSel and busWr held high together. The only other input is lowPwrMode, which is treated as a free level. The bench drives every input on the falling clock edge, so the synchronizer never samples a changing value. It holds each pin at its idle level for several clocks before a pulse, so that the filter starts from a settled state. It also times the simultaneous clear-and-set case by counting clock edges from the pin change rather than by watching internal signals.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_POLAR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd2;

  // one-cycle strobes from the bus decoder to the datapath
  typedef struct packed {
    logic enWr;
    logic polWr;
    logic flagClr;
  } ctrlStrobeT;

endpackage

// File: rtl/pinPulseFilter.sv
module pinPulseFilter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lvlIn,
  output logic lvlOut,
  output logic accept
);

  localparam int CNT_W = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             accLvl;
  logic             differs;

  assign differs = (lvlIn != accLvl);
  assign accept  = differs && (holdCnt == CNT_LAST);
  assign lvlOut  = accLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accLvl  <= 1'b0;
      holdCnt <= '0;
    end else if (!differs) begin
      holdCnt <= '0;
    end else if (holdCnt == CNT_LAST) begin
      accLvl  <= lvlIn;
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // R4: a level is only accepted once it has already differed on the clock before
  p_min_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> ($past(lvlIn) != $past(accLvl)));

  // R5: once accepted, the filter output follows the new level
  p_accept_takes_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (accLvl == $past(lvlIn)));

endmodule

// File: rtl/pinIrqBusCtrl.sv
module pinIrqBusCtrl
  import pinIrqPkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] enReg,
  input  logic [NUM_PINS-1:0] polReg,
  input  logic [NUM_PINS-1:0] flagReg,
  output ctrlStrobeT          strb,
  output logic [NUM_PINS-1:0] busRdata
);

  logic wrEvent;
  assign wrEvent = busSel && busWr;

  always_comb begin
    strb         = '0;
    strb.enWr    = wrEvent && (busAddr == ADDR_ENABLE);
    strb.polWr   = wrEvent && (busAddr == ADDR_POLAR);
    strb.flagClr = wrEvent && (busAddr == ADDR_FLAGS);
  end

  always_comb begin
    unique case (busAddr)
      ADDR_ENABLE: busRdata = enReg;
      ADDR_POLAR:  busRdata = polReg;
      ADDR_FLAGS:  busRdata = flagReg;
      default:     busRdata = '0;
    endcase
  end

  // R2: at most one register is written per access
  p_one_strobe_r2: assert final ($onehot0({strb.enWr, strb.polWr, strb.flagClr}));

endmodule

// File: rtl/pinIrqDatapath.sv
module pinIrqDatapath
  import pinIrqPkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctrlStrobeT          strb,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic                lowPwrMode,
  output logic [NUM_PINS-1:0] enReg,
  output logic [NUM_PINS-1:0] polReg,
  output logic [NUM_PINS-1:0] flagReg,
  output logic                irqReq,
  output logic                wakeReq
);

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncLvl;
  logic [NUM_PINS-1:0] acceptVec;
  logic [NUM_PINS-1:0] filtLvl;
  logic [NUM_PINS-1:0] setVec;
  logic [NUM_PINS-1:0] clrVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncChain[s] <= '0;
    end else begin
      syncChain[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncChain[s] <= syncChain[s-1];
    end
  end

  assign syncLvl = syncChain[SYNC_STAGES-1];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pinPulseFilter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
      .clk    (clk),
      .rstN   (rstN),
      .lvlIn  (syncLvl[i]),
      .lvlOut (filtLvl[i]),
      .accept (acceptVec[i])
    );
    assign setVec[i] = acceptVec[i] && (syncLvl[i] == polReg[i]);
  end

  assign clrVec = strb.flagClr ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      polReg  <= '0;
      flagReg <= '0;
    end else begin
      if (strb.enWr)  enReg  <= wdata;
      if (strb.polWr) polReg <= wdata;
      flagReg <= (flagReg & ~clrVec) | setVec;
    end
  end

  assign irqReq  = |(flagReg & enReg);
  assign wakeReq = irqReq && lowPwrMode;

  // R5 and R9: a qualified edge always leaves its flag set, even under a clear
  p_edge_sets_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((flagReg & $past(setVec)) == $past(setVec)));

  // R8: a cleared bit with no concurrent edge reads 0 afterwards
  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagClr |=> ((flagReg & $past(wdata & ~setVec)) == '0));

  // R11: a flag bit only rises on a qualified edge
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((flagReg & ~$past(flagReg) & ~$past(setVec)) == '0));

  // R3: a flag set means the filtered level now matches that pin's polarity
  p_polarity_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> (((filtLvl ^ $past(polReg)) & $past(setVec)) == '0));

endmodule

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl
  import pinIrqPkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic                lowPwrMode,
  output logic                irqReq,
  output logic                wakeReq
);

  ctrlStrobeT          strb;
  logic [NUM_PINS-1:0] enReg;
  logic [NUM_PINS-1:0] polReg;
  logic [NUM_PINS-1:0] flagReg;

  pinIrqBusCtrl #(.NUM_PINS(NUM_PINS)) ctrl_i (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .enReg    (enReg),
    .polReg   (polReg),
    .flagReg  (flagReg),
    .strb     (strb),
    .busRdata (busRdata)
  );

  pinIrqDatapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYCLES (FILT_CYCLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .strb       (strb),
    .wdata      (busWdata),
    .lowPwrMode (lowPwrMode),
    .enReg      (enReg),
    .polReg     (polReg),
    .flagReg    (flagReg),
    .irqReq     (irqReq),
    .wakeReq    (wakeReq)
  );

  // R10: no wake request outside low-power mode
  p_wake_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> lowPwrMode);

  // R7: the request needs at least one enabled pin
  p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enReg != '0));

endmodule

// File: tb/pinIrqCtrl_tb_top.sv
module pinIrqCtrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       lowPwrMode = 1'b0;
  logic       irqReq;
  logic       wakeReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pinIrqCtrl dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .lowPwrMode(lowPwrMode), .irqReq(irqReq), .wakeReq(wakeReq)
  );

  // vector fields: [8:6] pin, [5] polarity, [4:1] pulse width, [0] flag expected
  localparam int NVEC = 10;
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 4'd1, 1'b0},
    {3'd1, 1'b1, 4'd2, 1'b0},
    {3'd2, 1'b1, 4'd3, 1'b0},
    {3'd3, 1'b1, 4'd4, 1'b1},
    {3'd4, 1'b1, 4'd5, 1'b1},
    {3'd5, 1'b1, 4'd8, 1'b1},
    {3'd6, 1'b0, 4'd3, 1'b0},
    {3'd7, 1'b0, 4'd4, 1'b1},
    {3'd0, 1'b0, 4'd6, 1'b1},
    {3'd1, 1'b0, 4'd2, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    busRead(2'd0, rd); check("R1 enable", rd, 8'h00);
    busRead(2'd1, rd); check("R1 polarity", rd, 8'h00);
    busRead(2'd2, rd); check("R1 flags", rd, 8'h00);
    check("R1 irq/wake", {6'd0, irqReq, wakeReq}, 8'h00);

    // R2 register access
    waitCyc(1);
    busWrite(2'd0, 8'hA5);
    busRead(2'd0, rd); check("R2 enable readback", rd, 8'hA5);
    waitCyc(1);
    busWrite(2'd1, 8'h3C);
    busRead(2'd1, rd); check("R2 polarity readback", rd, 8'h3C);
    busRead(2'd3, rd); check("R2 address 3", rd, 8'h00);
    waitCyc(1);
    busWrite(2'd0, 8'h00);

    // R4/R5/R3 vector walk on the pulse filter
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] pin;
      logic       pol;
      logic [3:0] w;
      logic       ex;
      {pin, pol, w, ex} = VEC[v];
      busWrite(2'd1, 8'(pol) << pin);
      pinIn = '0;
      pinIn[pin] = ~pol;
      waitCyc(10);
      busWrite(2'd2, 8'hFF);
      pinIn[pin] = pol;
      waitCyc(int'(w));
      pinIn[pin] = ~pol;
      waitCyc(10);
      busRead(2'd2, rd);
      check(ex ? "R5 valid pulse" : "R4 glitch rejected", rd, 8'(ex) << pin);
    end

    // R3 opposite edge: rising selected, falling edge applied
    waitCyc(1);
    busWrite(2'd1, 8'h00);
    pinIn = 8'h01;
    waitCyc(10);
    busWrite(2'd1, 8'h01);
    busWrite(2'd2, 8'hFF);
    pinIn = 8'h00;
    waitCyc(10);
    busRead(2'd2, rd); check("R3 opposite edge ignored", rd, 8'h00);

    // R5 exact latency: pin 0 rising, flag after 6th edge
    waitCyc(1);
    pinIn = 8'h01;
    waitCyc(5);
    busRead(2'd2, rd); check("R5 not yet after 5 edges", rd, 8'h00);
    waitCyc(1);
    busRead(2'd2, rd); check("R5 set after 6 edges", rd, 8'h01);

    // R6 flag set while disabled, R7 no request yet
    check("R7 irq low while disabled", {7'd0, irqReq}, 8'h00);
    waitCyc(1);
    busWrite(2'd0, 8'h01);
    #1 check("R7 irq high when enabled", {7'd0, irqReq}, 8'h01);
    check("R10 wake low outside low-power", {7'd0, wakeReq}, 8'h00);
    lowPwrMode = 1'b1;
    #1 check("R10 wake follows irq", {7'd0, wakeReq}, 8'h01);
    waitCyc(1);
    busWrite(2'd0, 8'h02);
    #1 check("R7 irq low with other pin enabled", {6'd0, irqReq, wakeReq}, 8'h00);

    // R8 writing 0 keeps, writing 1 clears
    busWrite(2'd2, 8'h00);
    busRead(2'd2, rd); check("R8 zero write keeps flag", rd, 8'h01);
    waitCyc(1);
    busWrite(2'd2, 8'h01);
    busRead(2'd2, rd); check("R8 one write clears flag", rd, 8'h00);

    // R11 writes of ones never set flags
    waitCyc(1);
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, rd); check("R11 write cannot set", rd, 8'h00);

    // R9 set wins over same-cycle clear: pin 1, rising
    waitCyc(1);
    busWrite(2'd1, 8'h02);
    pinIn = 8'h00;
    waitCyc(10);
    busWrite(2'd2, 8'hFF);
    pinIn = 8'h02;
    waitCyc(4);
    busRead(2'd2, rd); check("R9 precondition clear", rd, 8'h00);
    waitCyc(1);
    busWrite(2'd2, 8'h02);
    busRead(2'd2, rd); check("R9 set beats clear", rd, 8'h02);
    #1 check("R10 wake in low-power", {6'd0, irqReq, wakeReq}, 8'h03);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule